// File: doc/BRIEF.md
# Lane-Partitioned Saturating Adder/Subtractor

This block is a purely combinational 64-bit adder/subtractor. A mode input can cut its carry chain at 8-bit, 16-bit or 32-bit boundaries, or leave the chain whole. The same datapath therefore computes eight 8-bit, four 16-bit, two 32-bit or one 64-bit sum at once. Each lane chooses three things: add or subtract, signed or unsigned, and saturate or wrap.

The datapath is split into eight 8-bit slices, numbered 0 (least significant) to 7. A lane is one or more adjacent slices. A lane's controls are read from the control bits of its top slice, the slice holding the lane's most significant byte. Its overflow flag is reported on that same slice. There is no state in the block, so no state machine or transitions exist. The result follows the inputs within the same cycle.

Top module: `simd_sat_adder`

## Requirements
- R1: `lane_mode` selects the lane width: 2'b00 gives 8-bit lanes, 2'b01 gives 16-bit lanes, 2'b10 gives 32-bit lanes and 2'b11 gives one 64-bit lane. No carry or borrow passes from one lane into the next.
- R2: With wrapping selected (saturate bit 0) and add selected (subtract bit 0), each lane returns (a + b) modulo 2^L, where L is the lane width.
- R3: With subtract selected (subtract bit 1), each lane computes a + ~b + 1. In wrapping mode the lane returns (a - b) modulo 2^L.
- R4: For a signed add, overflow occurs only when both operands have the same sign and the result sign differs from it. Operands of opposite sign never overflow.
- R5: For a signed subtract, overflow occurs only when the operand signs differ and the result sign differs from the sign of a.
- R6: For an unsigned add, overflow is a carry out of the lane's top bit. For an unsigned subtract, overflow is a borrow, meaning b > a.
- R7: A signed lane with saturation and overflow returns 0x7F..F when the true result is too large and 0x80..0 when it is too small.
- R8: An unsigned lane with saturation and overflow returns all ones for an add and zero for a subtract.
- R9: `ovf_out[k]` can be 1 only when slice k is the top slice of its lane. It is set whenever that lane overflows, whether or not saturation is selected. All other bits read 0.
- R10: A lane uses only the `sub_sel`, `signed_sel` and `sat_sel` bits of its top slice. The bits of its other slices have no effect on `sum_out` or `ovf_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 64 | First operand (minuend when subtracting) |
| b_in | input | 64 | Second operand (subtrahend when subtracting) |
| lane_mode | input | 2 | Lane width select: 00 = 8-bit, 01 = 16-bit, 10 = 32-bit, 11 = 64-bit |
| sub_sel | input | 8 | Per-slice subtract select; 1 = subtract |
| signed_sel | input | 8 | Per-slice signed select; 1 = signed (two's complement) |
| sat_sel | input | 8 | Per-slice saturate select; 1 = saturate, 0 = wrap |
| sum_out | output | 64 | Lane results |
| ovf_out | output | 8 | Per-slice overflow flags, valid on lane top slices |

## Verification
The cases hardest to reach from the ports are the wide-lane ones: a carry that has to ripple across an internal byte boundary of a 16-, 32- or 64-bit lane, and a lane's clamp value spread over slices whose own control bits say something else.

The bench builds operands by copying lane-width boundary values into every lane: zero, one, the signed extremes, all ones, and all ones minus one. This forces long carry ripples, and it forces overflow in every direction in every mode.

Random runs then fill the control bits of non-top slices with values that contradict the top slice. An exhaustive byte sweep covers every signed and unsigned overflow case of an 8-bit lane.

// File: rtl/simd_pkg.sv
package simd_pkg;
    localparam int SLICE_W = 8;
    localparam int SLICE_N = 8;

    typedef enum logic [1:0] {
        LANE_8  = 2'b00,
        LANE_16 = 2'b01,
        LANE_32 = 2'b10,
        LANE_64 = 2'b11
    } lane_mode_e;
endpackage

// File: rtl/simd_lane_map.sv
module simd_lane_map
    import simd_pkg::*;
#(
    parameter int N  = SLICE_N,
    localparam int IW = $clog2(N)
) (
    input  logic [1:0]            mode,
    output logic [N-1:0]          first_slice,
    output logic [N-1:0]          last_slice,
    output logic [N-1:0][IW-1:0]  top_idx
);
    logic [IW-1:0] span_m1;

    always_comb begin
        span_m1 = IW'((1 << mode) - 1);
        for (int i = 0; i < N; i++) begin
            first_slice[i] = ((IW'(i) & span_m1) == '0);
            last_slice[i]  = ((IW'(i) & span_m1) == span_m1);
            top_idx[i]     = IW'(i) | span_m1;
        end
    end
endmodule

// File: rtl/simd_slice_add.sv
module simd_slice_add #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         invert,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    always_comb begin
        {cout, sum} = {1'b0, a} + {1'b0, b ^ {W{invert}}} + {{W{1'b0}}, cin};
    end
endmodule

// File: rtl/simd_sat_fix.sv
module simd_sat_fix #(
    parameter int W = 8
) (
    input  logic [W-1:0] raw,
    input  logic         is_top,
    input  logic         lane_ovf,
    input  logic         lane_sat,
    input  logic         lane_signed,
    input  logic         lane_sub,
    input  logic         lane_a_sign,
    output logic [W-1:0] out
);
    logic fill;

    always_comb begin
        fill = lane_signed ? ~lane_a_sign : ~lane_sub;
        if (lane_ovf && lane_sat) begin
            if (lane_signed && is_top) out = {lane_a_sign, {(W-1){~lane_a_sign}}};
            else                       out = {W{fill}};
        end else begin
            out = raw;
        end
    end
endmodule

// File: rtl/simd_sat_adder.sv
module simd_sat_adder
    import simd_pkg::*;
#(
    parameter int W = SLICE_W,
    parameter int N = SLICE_N,
    localparam int IW = $clog2(N),
    localparam int DW = W * N
) (
    input  logic [DW-1:0] a_in,
    input  logic [DW-1:0] b_in,
    input  logic [1:0]    lane_mode,
    input  logic [N-1:0]  sub_sel,
    input  logic [N-1:0]  signed_sel,
    input  logic [N-1:0]  sat_sel,
    output logic [DW-1:0] sum_out,
    output logic [N-1:0]  ovf_out
);
    logic [N-1:0]          first_slice, last_slice;
    logic [N-1:0][IW-1:0]  top_idx;
    logic [N-1:0]          l_sub, l_sgn, l_sat;
    logic [N-1:0]          cin, cout, top_ovf;
    logic [N-1:0][W-1:0]   raw;

    simd_lane_map #(.N(N)) u_map (
        .mode        (lane_mode),
        .first_slice (first_slice),
        .last_slice  (last_slice),
        .top_idx     (top_idx)
    );

    always_comb begin
        for (int i = 0; i < N; i++) begin
            l_sub[i] = sub_sel[top_idx[i]];
            l_sgn[i] = signed_sel[top_idx[i]];
            l_sat[i] = sat_sel[top_idx[i]];
        end
    end

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_slice
            logic as, bs, rs, sov, uov;
            if (g == 0) begin : g_c0
                assign cin[g] = l_sub[g];
            end else begin : g_cn
                assign cin[g] = first_slice[g] ? l_sub[g] : cout[g-1];
            end

            simd_slice_add #(.W(W)) u_add (
                .a      (a_in[g*W +: W]),
                .b      (b_in[g*W +: W]),
                .invert (l_sub[g]),
                .cin    (cin[g]),
                .sum    (raw[g]),
                .cout   (cout[g])
            );

            assign as  = a_in[g*W + W - 1];
            assign bs  = b_in[g*W + W - 1];
            assign rs  = raw[g][W-1];
            assign sov = l_sub[g] ? ((as != bs) && (rs != as)) : ((as == bs) && (rs != as));
            assign uov = l_sub[g] ? ~cout[g] : cout[g];
            assign top_ovf[g] = last_slice[g] & (l_sgn[g] ? sov : uov);
            assign ovf_out[g] = top_ovf[g];

            simd_sat_fix #(.W(W)) u_fix (
                .raw         (raw[g]),
                .is_top      (last_slice[g]),
                .lane_ovf    (top_ovf[top_idx[g]]),
                .lane_sat    (l_sat[g]),
                .lane_signed (l_sgn[g]),
                .lane_sub    (l_sub[g]),
                .lane_a_sign (a_in[top_idx[g]*W + W - 1]),
                .out         (sum_out[g*W +: W])
            );
        end
    endgenerate
endmodule

// File: rtl/simd_sat_adder_chk.sv
module simd_sat_adder_chk #(
    parameter int W = 8,
    parameter int N = 8,
    localparam int DW = W * N
) (
    input logic [DW-1:0] a_in,
    input logic [DW-1:0] b_in,
    input logic [1:0]    lane_mode,
    input logic [N-1:0]  sub_sel,
    input logic [N-1:0]  signed_sel,
    input logic [N-1:0]  sat_sel,
    input logic [DW-1:0] sum_out,
    input logic [N-1:0]  ovf_out
);
    logic [7:0] top_mask;

    always_comb begin
        case (lane_mode)
            2'b00:   top_mask = 8'hFF;
            2'b01:   top_mask = 8'hAA;
            2'b10:   top_mask = 8'h88;
            default: top_mask = 8'h80;
        endcase
        p_flag_pos_r9: assert ((ovf_out & ~N'(top_mask)) == '0)
            else $error("ovf flag on a non-top slice");
        if (lane_mode == 2'b11 && !sat_sel[N-1]) begin
            p_wrap_full_r2: assert (sum_out == (sub_sel[N-1] ? a_in - b_in : a_in + b_in))
                else $error("64-bit wrap result wrong");
        end
        if (lane_mode == 2'b00) begin
            for (int i = 0; i < N; i++) begin
                if (signed_sel[i] && !sub_sel[i] && (a_in[i*W+W-1] != b_in[i*W+W-1])) begin
                    p_no_overflow_r4: assert (!ovf_out[i])
                        else $error("opposite-sign add flagged");
                end
                if (!signed_sel[i] && !sub_sel[i] && sat_sel[i] && ovf_out[i]) begin
                    p_usat_top_r8: assert (sum_out[i*W +: W] == {W{1'b1}})
                        else $error("unsigned add clamp wrong");
                end
                if (signed_sel[i] && sat_sel[i] && ovf_out[i]) begin
                    p_ssat_val_r7: assert (sum_out[i*W +: W] ==
                        {a_in[i*W+W-1], {(W-1){~a_in[i*W+W-1]}}})
                        else $error("signed clamp wrong");
                end
            end
        end
    end
endmodule

bind simd_sat_adder simd_sat_adder_chk #(.W(W), .N(N)) u_chk (
    .a_in       (a_in),
    .b_in       (b_in),
    .lane_mode  (lane_mode),
    .sub_sel    (sub_sel),
    .signed_sel (signed_sel),
    .sat_sel    (sat_sel),
    .sum_out    (sum_out),
    .ovf_out    (ovf_out)
);

// File: tb/simd_sat_adder_test.sv
module simd_sat_adder_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 190000;

    logic        clk = 1'b0;
    logic [63:0] a_in, b_in, sum_out;
    logic [1:0]  lane_mode;
    logic [7:0]  sub_sel, signed_sel, sat_sel, ovf_out;
    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    simd_sat_adder uut (
        .a_in(a_in), .b_in(b_in), .lane_mode(lane_mode),
        .sub_sel(sub_sel), .signed_sel(signed_sel), .sat_sel(sat_sel),
        .sum_out(sum_out), .ovf_out(ovf_out)
    );

    function automatic void model(input logic [63:0] a, b, input logic [1:0] m,
                                  input logic [7:0] sb, sg, st,
                                  output logic [63:0] r, output logic [7:0] f);
        int n, L;
        logic [63:0] mask;
        r = '0; f = '0;
        n = 1 << m;
        L = 8 * n;
        mask = (L == 64) ? '1 : ((64'd1 << L) - 64'd1);
        for (int l = 0; l < 8 / n; l++) begin
            int t;
            logic [63:0] ua, ub, res;
            logic signed [66:0] xa, xb, tv, mx, mn;
            logic ov;
            t  = l * n + n - 1;
            ua = (a >> (l * L)) & mask;
            ub = (b >> (l * L)) & mask;
            xa = {3'b0, ua};
            xb = {3'b0, ub};
            if (sg[t]) begin
                if (ua[L-1]) xa = xa - (67'sd1 <<< L);
                if (ub[L-1]) xb = xb - (67'sd1 <<< L);
                mx = (67'sd1 <<< (L - 1)) - 67'sd1;
                mn = -(67'sd1 <<< (L - 1));
            end else begin
                mx = {3'b0, mask};
                mn = '0;
            end
            tv  = sb[t] ? xa - xb : xa + xb;
            ov  = (tv > mx) || (tv < mn);
            res = tv[63:0] & mask;
            if (ov && st[t]) res = (tv > mx) ? (mx[63:0] & mask) : (mn[63:0] & mask);
            r = r | (res << (l * L));
            f[t] = ov;
        end
    endfunction

    task automatic run(input logic [63:0] a, b, input logic [1:0] m,
                       input logic [7:0] sb, sg, st, input string tag);
        logic [63:0] er;
        logic [7:0]  ef;
        a_in = a; b_in = b; lane_mode = m;
        sub_sel = sb; signed_sel = sg; sat_sel = st;
        #1;
        model(a, b, m, sb, sg, st, er, ef);
        checks++;
        if (sum_out !== er || ovf_out !== ef) begin
            failures++;
            $display("FAIL %s mode=%0d a=%h b=%h sub=%h sgn=%h sat=%h: got %h/%h expected %h/%h",
                     tag, m, a, b, sb, sg, st, sum_out, ovf_out, er, ef);
        end
        #1;
    endtask

    function automatic logic [63:0] spread(input logic [63:0] v, input int L);
        logic [63:0] r = '0;
        for (int l = 0; l < 64 / L; l++) r = r | (v << (l * L));
        return r;
    endfunction

    initial begin
        logic [63:0] bnd [6];
        // reset-state style check: all-zero inputs give zero and no flags (R2)
        run(64'd0, 64'd0, 2'b00, 8'h00, 8'h00, 8'h00, "R2 zero");
        // carry isolation at every boundary (R1)
        run({8{8'hFF}}, {8{8'h01}}, 2'b00, 8'h00, 8'h00, 8'h00, "R1 byte lanes");
        run({4{16'hFFFF}}, {4{16'h0001}}, 2'b01, 8'h00, 8'h00, 8'h00, "R1 16-bit lanes");
        run({2{32'hFFFFFFFF}}, {2{32'h1}}, 2'b10, 8'h00, 8'h00, 8'h00, "R1 32-bit lanes");
        run(64'hFFFFFFFFFFFFFFFF, 64'd1, 2'b11, 8'h00, 8'h00, 8'h00, "R1 full lane");
        run(64'd0, {8{8'h01}}, 2'b00, 8'hFF, 8'h00, 8'h00, "R3 borrow isolation");
        // boundary sweep in every mode and uniform control combination
        for (int m = 0; m < 4; m++) begin
            int L;
            L = 8 << m;
            bnd[0] = 64'd0;
            bnd[1] = 64'd1;
            bnd[2] = (L == 64) ? 64'h7FFFFFFFFFFFFFFF : ((64'd1 << (L - 1)) - 64'd1);
            bnd[3] = 64'd1 << (L - 1);
            bnd[4] = (L == 64) ? '1 : ((64'd1 << L) - 64'd1);
            bnd[5] = bnd[4] - 64'd1;
            for (int i = 0; i < 6; i++)
                for (int j = 0; j < 6; j++)
                    for (int c = 0; c < 8; c++)
                        run(spread(bnd[i], L), spread(bnd[j], L), 2'(m),
                            {8{c[0]}}, {8{c[1]}}, {8{c[2]}},
                            "R1 R4 R5 R6 R7 R8 R9 boundary");
        end
        // exhaustive byte sweep, saturating and flagging, all sign/op combos
        for (int x = 0; x < 256; x++)
            for (int y = 0; y < 256; y++)
                for (int c = 0; c < 4; c++)
                    run({8{8'(x)}}, {8{8'(y)}}, 2'b00, {8{c[0]}}, {8{c[1]}}, 8'hFF,
                        "R3 R4 R5 R6 R7 R8 byte sweep");
        // random data and per-slice controls; non-top bits must be ignored
        for (int k = 0; k < 4000; k++)
            run({$urandom, $urandom}, {$urandom, $urandom}, 2'($urandom),
                8'($urandom), 8'($urandom), 8'($urandom), "R2 R9 R10 random");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule